// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the software-facing register front end of a 24-input interrupt redirection controller. Software reaches every internal register through two locations: an 8-bit selector and a 32-bit data window. The selector picks the controller identifier, the version word, the arbitration identifier, or one 32-bit half of a 64-bit redirection entry. Reads and writes through the window then act on the selected register.

The block owns the redirection table. It enforces which entry bits software may change. The remote-IRR flag and the delivery-status flag belong to the delivery logic. It clears remote IRR whenever a written entry ends up edge-triggered. It applies the reset defaults, with every input masked. The whole table is exported as a flat vector. A single-cycle event marks each mask change made by software, so a downstream delivery block can react to it.

Top module: `irw_regwin`

## Requirements
- R1: Offset 0x00 is the selector. A write keeps `bus_wdata[7:0]`, and a read returns the selector zero-extended to 32 bits.
- R2: Any bus offset other than 0x00 and 0x10 reads as zero, and writes to it change nothing.
- R3: Selector 0x01 reads `{8'h00, NUM_PINS-1, 8'h00, VER_CODE}` (fields at bits 31:24, 23:16, 15:8 and 7:0), and window writes to it are ignored.
- R4: A window write with selector 0x00 stores `bus_wdata[27:24]` as the 4-bit identifier. Selector 0x00 and selector 0x02 both read it at bits 27:24, with all other bits zero. Window writes with selector 0x02 are ignored.
- R5: A selector S ≥ 0x10 addresses entry (S−0x10)>>1. An odd S maps the window to entry bits 63:32 and an even S maps it to bits 31:0. Entry bit fields are: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger mode 15 (1 = level, 0 = edge), mask 16, destination 63:56.
- R6: A selector that addresses no entry or register reads all ones through the window, and window writes to it change nothing. This covers S in 0x03..0x0F and S ≥ 0x10+2·NUM_PINS.
- R7: Software writes never change remote IRR or delivery status. Remote IRR is set by `rirr_set[i]`, which wins over `rirr_clr[i]`, and cleared by `rirr_clr[i]`. Delivery status shows `dlv_busy[i]` as sampled at the previous clock edge.
- R8: After any write to either half of an entry, if the entry's trigger bit is 0 (edge), its remote IRR is 0.
- R9: A low-half write that changes an entry's mask bit raises `mask_evt` for exactly the one cycle after the write strobe, with `mask_evt_pin` set to the entry index and `mask_evt_val` set to the new mask. High-half writes and writes that leave the mask unchanged raise no event.
- R10: Reset clears the selector and the identifier. It loads every entry with mask = 1 and all other bits 0.
- R11: Read data appears on `bus_rdata` in the cycle after the `bus_rd` strobe and is zero in any other cycle. A write takes effect at the clock edge that samples its strobe.
- R12: `tbl_o[64*i+63 : 64*i]` always holds entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset inside the register region |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| rirr_set | input | NUM_PINS | Per-entry remote IRR set from the delivery logic |
| rirr_clr | input | NUM_PINS | Per-entry remote IRR clear (end of interrupt) |
| dlv_busy | input | NUM_PINS | Per-entry delivery-in-progress flag |
| tbl_o | output | 64*NUM_PINS | Flat copy of the whole redirection table |
| mask_evt | output | 1 | One-cycle mask-change event |
| mask_evt_pin | output | $clog2(NUM_PINS) | Entry index of the mask change |
| mask_evt_val | output | 1 | New mask value |

## Verification
The hardest state to reach from the ports is an entry whose hardware-owned flags are set while software rewrites it. The delivery inputs have to raise remote IRR and delivery status first. Software then writes data that tries to clear or set those bits, and the readback must show them untouched. The stimulus repeats this with a high-half write on a level entry, which must keep remote IRR, and on an edge entry, which must drop it. Every expected readback goes through a scoreboard queue that lines it up with the cycle after each read strobe.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int DATA_W = 32;
    localparam int ENT_W  = 64;

    // Entry bit positions decoded by the delivery block
    localparam int B_DSTAT = 12;
    localparam int B_RIRR  = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;

    localparam logic [7:0] OFS_SEL        = 8'h00;
    localparam logic [7:0] OFS_WIN        = 8'h10;
    localparam logic [7:0] SEL_ID         = 8'h00;
    localparam logic [7:0] SEL_VER        = 8'h01;
    localparam logic [7:0] SEL_ARB        = 8'h02;
    localparam logic [7:0] SEL_ENTRY_BASE = 8'h10;

    localparam logic [ENT_W-1:0] ENT_RST = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        SK_ID,
        SK_VER,
        SK_ARB,
        SK_ENTRY,
        SK_VOID
    } sel_kind_e;

    typedef struct packed {
        logic [ENT_W-1:0] ent;
        logic             tgl;
    } slot_state_t;

    typedef struct packed {
        logic [7:0]        sel;
        logic [3:0]        id;
        logic [DATA_W-1:0] rdata;
    } front_state_t;

endpackage

// File: rtl/irw_sel_decode.sv
module irw_sel_decode
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic [7:0]       sel,
    output sel_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);

    logic [7:0] off;
    logic [6:0] ent_num;

    always_comb begin
        off     = sel - SEL_ENTRY_BASE;
        ent_num = off[7:1];
        idx     = ent_num[IDX_W-1:0];
        hi      = sel[0];
        if (sel == SEL_ID)
            kind = SK_ID;
        else if (sel == SEL_VER)
            kind = SK_VER;
        else if (sel == SEL_ARB)
            kind = SK_ARB;
        else if (sel >= SEL_ENTRY_BASE && int'(ent_num) < NUM_PINS)
            kind = SK_ENTRY;
        else
            kind = SK_VOID;
    end

endmodule

// File: rtl/irw_entry_slot.sv
module irw_entry_slot
    import irw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rirr_set,
    input  logic              rirr_clr,
    input  logic              dstat,
    output logic [ENT_W-1:0]  ent_o,
    output logic              mask_tgl_o
);

    slot_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tgl = 1'b0;
        if (wr_lo) begin
            st_d.ent[31:0] = wdata;
            st_d.tgl       = (wdata[B_MASK] != st_q.ent[B_MASK]);
        end
        if (wr_hi)
            st_d.ent[63:32] = wdata;
        // hardware-owned flags: bus data never lands here
        st_d.ent[B_DSTAT] = dstat;
        st_d.ent[B_RIRR]  = st_q.ent[B_RIRR];
        if (rirr_set)
            st_d.ent[B_RIRR] = 1'b1;
        else if (rirr_clr)
            st_d.ent[B_RIRR] = 1'b0;
        if ((wr_lo || wr_hi) && !st_d.ent[B_TRIG])
            st_d.ent[B_RIRR] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ent <= ENT_RST;
            st_q.tgl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_o      = st_q.ent;
    assign mask_tgl_o = st_q.tgl;

    AST_EDGE_RIRR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> (st_q.ent[B_TRIG] || !st_q.ent[B_RIRR])); // R8
    AST_RIRR_NOT_BY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rirr_set) |=> !$rose(st_q.ent[B_RIRR])); // R7
    AST_DSTAT_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.ent[B_DSTAT] == $past(dstat))); // R7
    AST_LOW_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo) |=> $stable(st_q.ent[11:0])); // R5

endmodule

// File: rtl/irw_regwin.sv
module irw_regwin
    import irw_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VER_CODE = 8'h20,
    localparam int        IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PINS-1:0]       rirr_set,
    input  logic [NUM_PINS-1:0]       rirr_clr,
    input  logic [NUM_PINS-1:0]       dlv_busy,
    output logic [64*NUM_PINS-1:0]    tbl_o,
    output logic                      mask_evt,
    output logic [IDX_W-1:0]          mask_evt_pin,
    output logic                      mask_evt_val
);

    localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);

    front_state_t      st_d, st_q;
    sel_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic              hi;
    logic              win_wr;
    logic              ent_wr;
    logic [NUM_PINS-1:0] wr_lo_v, wr_hi_v, tgl_v;
    logic [ENT_W-1:0]  ent_a [NUM_PINS];
    logic [DATA_W-1:0] win_val;

    irw_sel_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
        .sel  (st_q.sel),
        .kind (kind),
        .idx  (idx),
        .hi   (hi)
    );

    assign win_wr = bus_wr && (bus_addr == OFS_WIN);
    assign ent_wr = win_wr && (kind == SK_ENTRY);

    generate
        for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_slot
            assign wr_lo_v[gi] = ent_wr && (idx == IDX_W'(gi)) && !hi;
            assign wr_hi_v[gi] = ent_wr && (idx == IDX_W'(gi)) && hi;

            irw_entry_slot u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_lo      (wr_lo_v[gi]),
                .wr_hi      (wr_hi_v[gi]),
                .wdata      (bus_wdata),
                .rirr_set   (rirr_set[gi]),
                .rirr_clr   (rirr_clr[gi]),
                .dstat      (dlv_busy[gi]),
                .ent_o      (ent_a[gi]),
                .mask_tgl_o (tgl_v[gi])
            );

            assign tbl_o[64*gi +: 64] = ent_a[gi];
        end
    endgenerate

    // window read value for the current selector
    always_comb begin
        case (kind)
            SK_ID, SK_ARB: win_val = {4'h0, st_q.id, 24'h0};
            SK_VER:        win_val = {8'h00, LAST_PIN, 8'h00, VER_CODE};
            SK_ENTRY:      win_val = hi ? ent_a[idx][63:32] : ent_a[idx][31:0];
            default:       win_val = '1;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (bus_wr && bus_addr == OFS_SEL)
            st_d.sel = bus_wdata[7:0];
        if (win_wr && kind == SK_ID)
            st_d.id = bus_wdata[27:24];
        if (bus_rd) begin
            if (bus_addr == OFS_SEL)
                st_d.rdata = {24'h0, st_q.sel};
            else if (bus_addr == OFS_WIN)
                st_d.rdata = win_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel   <= '0;
            st_q.id    <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    // mask-change event encode; at most one entry is written per cycle
    always_comb begin
        mask_evt     = |tgl_v;
        mask_evt_pin = '0;
        mask_evt_val = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (tgl_v[i]) begin
                mask_evt_pin = IDX_W'(i);
                mask_evt_val = ent_a[i][B_MASK];
            end
        end
    end

    AST_SEL_ONLY_AT_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_SEL) |=> $stable(st_q.sel)); // R1
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> (bus_rdata == '0)); // R11
    AST_SINGLE_MASK_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgl_v)); // R9
    AST_ID_ONLY_BY_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && kind == SK_ID) |=> $stable(st_q.id)); // R4

endmodule

// File: tb/sim_irw_regwin.sv
module sim_irw_regwin;

    localparam int NP = 24;
    localparam int IW = $clog2(NP);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     rirr_set = '0;
    logic [NP-1:0]     rirr_clr = '0;
    logic [NP-1:0]     dlv_busy = '0;
    logic [64*NP-1:0]  tbl_o;
    logic              mask_evt;
    logic [IW-1:0]     mask_evt_pin;
    logic              mask_evt_val;

    always #10 clk = ~clk;

    irw_regwin #(.NUM_PINS(NP), .VER_CODE(8'h20)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .rirr_set     (rirr_set),
        .rirr_clr     (rirr_clr),
        .dlv_busy     (dlv_busy),
        .tbl_o        (tbl_o),
        .mask_evt     (mask_evt),
        .mask_evt_pin (mask_evt_pin),
        .mask_evt_val (mask_evt_val)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: read data is due one cycle after the strobe
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        logic [31:0] e;
        string       t;
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected read data", 64'(bus_rdata), 64'h0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic sel_to(input logic [7:0] s);
        bus_write(8'h00, {24'h0, s});
    endtask

    task automatic win_rd(input logic [31:0] exp, input string tag);
        bus_read(8'h10, exp, tag);
    endtask

    task automatic pulse_set(input int p);
        rirr_set[p] = 1'b1;
        @(negedge clk);
        rirr_set[p] = 1'b0;
    endtask

    task automatic pulse_clr(input int p);
        rirr_clr[p] = 1'b1;
        @(negedge clk);
        rirr_clr[p] = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 R12: reset state
        chk("R10 R9 no event after reset", 64'(mask_evt), 64'h0);
        chk("R10 R12 entry0 reset", tbl_o[0 +: 64], 64'h0000_0000_0001_0000);
        chk("R10 R12 entry23 reset", tbl_o[23*64 +: 64], 64'h0000_0000_0001_0000);
        bus_read(8'h00, 32'h0, "R10 R1 selector reset");
        win_rd(32'h0, "R10 R4 id reset");
        sel_to(8'h10);
        win_rd(32'h0001_0000, "R10 R5 entry0 low reset");

        // R1: selector keeps 8 bits
        bus_write(8'h00, 32'h0000_01AB);
        bus_read(8'h00, 32'h0000_00AB, "R1 selector low byte");
        win_rd(32'hFFFF_FFFF, "R6 selector 0xAB beyond table");

        // R2: other offsets
        bus_read(8'h08, 32'h0, "R2 offset 0x08 reads zero");
        bus_write(8'h20, 32'h0000_0055);
        bus_read(8'h00, 32'h0000_00AB, "R2 write to 0x20 ignored");
        bus_read(8'h14, 32'h0, "R2 offset 0x14 reads zero");

        // R11: idle cycle reads zero
        @(negedge clk);
        chk("R11 rdata zero without strobe", 64'(bus_rdata), 64'h0);

        // R3: version
        sel_to(8'h01);
        win_rd(32'h0017_0020, "R3 version word");
        bus_write(8'h10, 32'hFFFF_FFFF);
        win_rd(32'h0017_0020, "R3 version write ignored");

        // R4: identifier
        sel_to(8'h00);
        bus_write(8'h10, 32'hFA00_1234);
        win_rd(32'h0A00_0000, "R4 id readback");
        sel_to(8'h02);
        win_rd(32'h0A00_0000, "R4 arbitration id mirrors id");
        bus_write(8'h10, 32'h0500_0000);
        win_rd(32'h0A00_0000, "R4 arbitration write ignored");
        sel_to(8'h00);
        win_rd(32'h0A00_0000, "R4 id after arb write");

        // R5 R9 R12: entry 5 halves, unmask event
        sel_to(8'h1A);
        bus_write(8'h10, 32'h0000_A0F3);
        chk("R9 unmask event", 64'(mask_evt), 64'h1);
        chk("R9 event pin", 64'(mask_evt_pin), 64'd5);
        chk("R9 event value", 64'(mask_evt_val), 64'h0);
        @(negedge clk);
        chk("R9 event single cycle", 64'(mask_evt), 64'h0);
        win_rd(32'h0000_A0F3, "R5 entry5 low readback");
        sel_to(8'h1B);
        bus_write(8'h10, 32'hC500_0000);
        chk("R9 high half raises no event", 64'(mask_evt), 64'h0);
        win_rd(32'hC500_0000, "R5 entry5 high readback");
        chk("R12 entry5 export", tbl_o[5*64 +: 64], 64'hC500_0000_0000_A0F3);
        chk("R5 entry4 untouched", tbl_o[4*64 +: 64], 64'h0000_0000_0001_0000);

        // R6: out of range
        sel_to(8'h40);
        win_rd(32'hFFFF_FFFF, "R6 first index past table");
        bus_write(8'h10, 32'h1234_5678);
        chk("R6 entry23 unchanged", tbl_o[23*64 +: 64], 64'h0000_0000_0001_0000);
        chk("R6 entry0 unchanged", tbl_o[0 +: 64], 64'h0000_0000_0001_0000);
        sel_to(8'h05);
        win_rd(32'hFFFF_FFFF, "R6 hole below table");
        sel_to(8'h3F);
        bus_write(8'h10, 32'hAA00_0000);
        win_rd(32'hAA00_0000, "R5 last entry high half");
        chk("R12 entry23 export", tbl_o[23*64 +: 64], 64'hAA00_0000_0001_0000);

        // R7: hardware-owned flags
        dlv_busy[5] = 1'b1;
        pulse_set(5);
        sel_to(8'h1A);
        win_rd(32'h0000_F0F3, "R7 flags raised by delivery");
        bus_write(8'h10, 32'h0000_8044);
        chk("R9 same mask no event", 64'(mask_evt), 64'h0);
        win_rd(32'h0000_D044, "R7 write keeps flags set");
        dlv_busy[5] = 1'b0;
        pulse_clr(5);
        bus_write(8'h10, 32'h0000_D044);
        win_rd(32'h0000_8044, "R7 write cannot set flags");

        // R8: edge forces remote IRR low
        pulse_set(5);
        win_rd(32'h0000_C044, "R8 level keeps remote IRR");
        sel_to(8'h1B);
        bus_write(8'h10, 32'h1200_0000);
        sel_to(8'h1A);
        win_rd(32'h0000_C044, "R8 high write on level keeps IRR");
        bus_write(8'h10, 32'h0000_0044);
        win_rd(32'h0000_0044, "R8 switch to edge clears IRR");
        pulse_set(5);
        win_rd(32'h0000_4044, "R7 delivery sets IRR on edge entry");
        sel_to(8'h1B);
        bus_write(8'h10, 32'h1200_0000);
        sel_to(8'h1A);
        win_rd(32'h0000_0044, "R8 high write on edge clears IRR");

        // R9: re-mask and another pin
        bus_write(8'h10, 32'h0001_0044);
        chk("R9 remask event", 64'(mask_evt), 64'h1);
        chk("R9 remask pin", 64'(mask_evt_pin), 64'd5);
        chk("R9 remask value", 64'(mask_evt_val), 64'h1);
        sel_to(8'h10);
        bus_write(8'h10, 32'h0000_0000);
        chk("R9 pin0 event", 64'(mask_evt), 64'h1);
        chk("R9 pin0 index", 64'(mask_evt_pin), 64'd0);
        chk("R9 pin0 value", 64'(mask_evt_val), 64'h0);

        @(negedge clk);
        @(negedge clk);
        chk("R11 all reads answered", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule